// File: doc/BRIEF.md
# Controller Command Responder with Seconds Clock

This block sits behind a host link and acts as the command side of a small system controller. The host delivers a finished packet as a stream of bytes, and the last byte is marked. The block decodes a two-level header. The first byte selects the packet class: 0 for an auxiliary-bus transaction and 1 for a controller command. For controller commands, the second byte is the command code. The block answers each packet with a framed reply on an outgoing byte stream, and the length of that reply is shown for as long as it is being drained.

The block keeps a 32-bit seconds counter, which advances on an external one-second tick. The host can set and read this counter as a big-endian value that counts seconds from the start of 1904. An autopoll switch makes the block query the auxiliary bus at a fixed interval, `POLL_CYCLES` clock cycles, which is 50 Hz at the intended clock rate. Any device data that comes back is forwarded to the host as an unsolicited reply. Auxiliary-bus transactions go out to an external port, and the block only frames their results. A power-off command and a restart command each raise a one-cycle request pulse once their acknowledgement has fully left the block.

Top module: `cmd_responder`

## Requirements
- R1: After reset, `out_valid`, `aux_go`, `shutdown_req` and `reset_req` are low, autopoll is off (so no poll is ever issued), and the seconds counter reads 0.
- R2: A packet whose first byte is neither 0 nor 1, or a class-1 packet whose command code (second byte) is not listed in R3, R4, R5, R7 or R8, produces no reply. Missing packet bytes read as 0.
- R3: Command 0x01 (poll switch) with argument byte A (third byte) replies {0x01, A}. It turns autopoll on when A is nonzero and off when A is zero.
- R4: Command 0x09 loads the seconds counter from bytes 2..5, most significant byte first, and replies {0x01, 0x00, 0x00}.
- R5: Command 0x03 replies with seven bytes, {0x01, 0x00, 0x00, T[31:24], T[23:16], T[15:8], T[7:0]}, where T is the current seconds count.
- R6: Each `sec_tick` pulse adds 1 to the seconds counter, wrapping at 2^32. A load from R4 takes priority over a tick in the same cycle.
- R7: Commands 0x13, 0x14, 0x19 and 0x21 change nothing and reply {0x01, 0x00}.
- R8: Commands 0x0A and 0x11 reply {0x01, 0x00}. In the cycle after the final reply byte is accepted, 0x0A pulses `shutdown_req` for one cycle and 0x11 pulses `reset_req` for one cycle.
- R9: A class-0 packet of length L pulses `aux_go` with `aux_poll`=0. It presents `aux_req_len`=L-1 and puts packet bytes 1.. on `aux_req_data` (byte 1 in bits 7:0). When `aux_done` arrives with status 0 and count n, the reply is {0x00, 0x00, d0..d(n-1)}, with n clamped to `AUX_MAX`. A nonzero status S gives the reply {0x00, S}.
- R10: While autopoll is on, one poll (`aux_go` with `aux_poll`=1) is issued every `POLL_CYCLES` cycles. A poll that returns status 0 with n>0 bytes replies {0x00, 0x40, d0..d(n-1)}. A poll that returns no data produces no reply.
- R11: A reply is sent in byte order. `out_len` stays constant through the reply, `out_last` marks the final byte, and bytes and length hold steady while `out_ready` is low.
- R12: A packet whose first byte arrives while an earlier packet is awaiting the auxiliary bus or draining its reply is dropped whole and never answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet byte valid |
| in_data | input | 8 | Incoming packet byte |
| in_last | input | 1 | Marks the final byte of a packet |
| sec_tick | input | 1 | One-second tick |
| out_valid | output | 1 | Reply byte valid |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final reply byte |
| out_len | output | LW | Total length of the reply being sent |
| out_ready | input | 1 | Consumer accepts the reply byte |
| aux_go | output | 1 | One-cycle start of an auxiliary-bus transaction |
| aux_poll | output | 1 | The transaction is an autopoll query |
| aux_req_len | output | LW | Request byte count (packet length minus 1) |
| aux_req_data | output | 8*(IN_MAX-1) | Request bytes, first in bits 7:0 |
| aux_done | input | 1 | Transaction finished |
| aux_status | input | 8 | 0 on success, error code otherwise |
| aux_cnt | input | AW | Number of returned data bytes |
| aux_data | input | 8*AUX_MAX | Returned data, first byte in bits 7:0 |
| shutdown_req | output | 1 | Power-off request pulse |
| reset_req | output | 1 | System restart request pulse |

## Verification
The assertions take three things for granted about the environment. First, `aux_done` arrives only once per `aux_go` and only while a transaction is outstanding. Second, `out_ready` may stall at any time. Third, packets are at most `IN_MAX` bytes where their content matters. The stimulus follows these rules with a modelled auxiliary device that answers exactly once, two cycles after each start. When a command has to be sent while autopoll runs, the bench waits a few cycles after a poll has finished, so the command does not collide with a poll by accident. The busy-drop case is still provoked on purpose by stalling `out_ready`.

// File: rtl/resp_pkg.sv
package resp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_AUX  = 2'd1,
        ST_SEND = 2'd2
    } resp_st_e;

    localparam logic [7:0] CLS_AUX        = 8'h00;
    localparam logic [7:0] CLS_CTL        = 8'h01;
    localparam logic [7:0] OP_POLL_SWITCH = 8'h01;
    localparam logic [7:0] OP_READ_CLOCK  = 8'h03;
    localparam logic [7:0] OP_LOAD_CLOCK  = 8'h09;
    localparam logic [7:0] OP_POWER_OFF   = 8'h0A;
    localparam logic [7:0] OP_RESTART     = 8'h11;
    localparam logic [7:0] OP_ACK_A       = 8'h13;
    localparam logic [7:0] OP_ACK_B       = 8'h14;
    localparam logic [7:0] OP_ACK_C       = 8'h19;
    localparam logic [7:0] OP_ACK_D       = 8'h21;
    localparam logic [7:0] POLL_MARK      = 8'h40;
endpackage

// File: rtl/resp_rx_asm.sv
module resp_rx_asm #(
    parameter int IN_MAX = 8,
    parameter int LW     = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [7:0]               in_data,
    input  logic                     in_last,
    input  logic                     busy,
    output logic                     pkt_done,
    output logic [LW-1:0]            pkt_len,
    output logic [IN_MAX-1:0][7:0]   pkt_bytes,
    output logic                     active
);
    localparam int IW = (IN_MAX > 1) ? $clog2(IN_MAX) : 1;
    localparam logic [LW-1:0] LEN_SAT = '1;

    typedef struct packed {
        logic [LW-1:0]          cnt;
        logic                   drop;
        logic                   done;
        logic [LW-1:0]          len;
        logic [IN_MAX-1:0][7:0] bytes;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        if (in_valid) begin
            if (rx_q.drop) begin
                if (in_last) rx_d.drop = 1'b0;
            end else if (rx_q.cnt == '0) begin
                if (busy) begin
                    rx_d.drop = !in_last;
                end else begin
                    rx_d.bytes    = '0;
                    rx_d.bytes[0] = in_data;
                    if (in_last) begin
                        rx_d.done = 1'b1;
                        rx_d.len  = LW'(1);
                    end else begin
                        rx_d.cnt = LW'(1);
                    end
                end
            end else begin
                if (int'(rx_q.cnt) < IN_MAX) rx_d.bytes[rx_q.cnt[IW-1:0]] = in_data;
                if (in_last) begin
                    rx_d.done = 1'b1;
                    rx_d.len  = (rx_q.cnt == LEN_SAT) ? LEN_SAT : rx_q.cnt + 1'b1;
                    rx_d.cnt  = '0;
                end else if (rx_q.cnt != LEN_SAT) begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign pkt_done  = rx_q.done;
    assign pkt_len   = rx_q.len;
    assign pkt_bytes = rx_q.bytes;
    assign active    = (rx_q.cnt != '0) || rx_q.drop;
endmodule

// File: rtl/resp_seconds.sv
module resp_seconds #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    output logic [SW-1:0] secs
);
    logic [SW-1:0] secs_d, secs_q;

    always_comb begin
        secs_d = secs_q;
        if (load)      secs_d = load_val;
        else if (tick) secs_d = secs_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) secs_q <= '0;
        else        secs_q <= secs_d;
    end

    assign secs = secs_q;
endmodule

// File: rtl/resp_poll_div.sv
module resp_poll_div #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    output logic due
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          due;
    } div_t;

    div_t dv_d, dv_q;

    always_comb begin
        dv_d     = dv_q;
        dv_d.due = 1'b0;
        if (!enable || restart) begin
            dv_d.cnt = '0;
        end else if (dv_q.cnt == LAST) begin
            dv_d.cnt = '0;
            dv_d.due = 1'b1;
        end else begin
            dv_d.cnt = dv_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign due = dv_q.due;
endmodule

// File: rtl/resp_tx_buf.sv
module resp_tx_buf #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [LW-1:0]          load_len,
    input  logic [DEPTH-1:0][7:0]  load_bytes,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [7:0]             out_data,
    output logic                   out_last,
    output logic [LW-1:0]          out_len,
    output logic                   done
);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic                  act;
        logic [LW-1:0]         idx;
        logic [LW-1:0]         len;
        logic [DEPTH-1:0][7:0] bytes;
    } tx_t;

    tx_t tx_d, tx_q;
    logic at_end;

    assign at_end = (tx_q.idx == tx_q.len - 1'b1);

    always_comb begin
        tx_d = tx_q;
        if (load) begin
            tx_d.act   = 1'b1;
            tx_d.idx   = '0;
            tx_d.len   = load_len;
            tx_d.bytes = load_bytes;
        end else if (tx_q.act && out_ready) begin
            if (at_end) tx_d.act = 1'b0;
            else        tx_d.idx = tx_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign out_valid = tx_q.act;
    assign out_data  = tx_q.bytes[tx_q.idx[IW-1:0]];
    assign out_last  = tx_q.act && at_end;
    assign out_len   = tx_q.len;
    assign done      = tx_q.act && out_ready && at_end;
endmodule

// File: rtl/cmd_responder.sv
module cmd_responder
    import resp_pkg::*;
#(
    parameter int IN_MAX      = 8,
    parameter int RBUF        = 16,
    parameter int AUX_MAX     = 8,
    parameter int POLL_CYCLES = 1000,
    localparam int LW         = $clog2(RBUF + 1),
    localparam int AW         = $clog2(AUX_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    input  logic                    in_last,
    input  logic                    sec_tick,
    output logic                    out_valid,
    output logic [7:0]              out_data,
    output logic                    out_last,
    output logic [LW-1:0]           out_len,
    input  logic                    out_ready,
    output logic                    aux_go,
    output logic                    aux_poll,
    output logic [LW-1:0]           aux_req_len,
    output logic [8*(IN_MAX-1)-1:0] aux_req_data,
    input  logic                    aux_done,
    input  logic [7:0]              aux_status,
    input  logic [AW-1:0]           aux_cnt,
    input  logic [8*AUX_MAX-1:0]    aux_data,
    output logic                    shutdown_req,
    output logic                    reset_req
);
    localparam int SW   = 32;
    localparam int DMAX = (AUX_MAX < RBUF - 2) ? AUX_MAX : RBUF - 2;

    typedef struct packed {
        resp_st_e                  st;
        logic                      autopoll;
        logic                      poll_pend;
        logic                      poll_fly;
        logic                      go;
        logic [LW-1:0]             req_len;
        logic [8*(IN_MAX-1)-1:0]   req_data;
        logic                      pend_off;
        logic                      pend_rst;
        logic                      off_pulse;
        logic                      rst_pulse;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  pkt_done, rx_active, rx_busy;
    logic [LW-1:0]         pkt_len;
    logic [IN_MAX-1:0][7:0] pkt;
    logic [SW-1:0]         sec_now, sec_val;
    logic                  sec_load;
    logic                  poll_due, div_restart;
    logic                  tx_load, tx_done;
    logic [LW-1:0]         tx_len;
    logic [RBUF-1:0][7:0]  rb;
    logic [AW-1:0]         n_ret;

    assign rx_busy = (ctl_q.st != ST_IDLE) || pkt_done;

    resp_rx_asm #(.IN_MAX(IN_MAX), .LW(LW)) u_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .busy(rx_busy), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .pkt_bytes(pkt), .active(rx_active)
    );

    resp_seconds #(.SW(SW)) u_sec (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(sec_load),
        .load_val(sec_val), .secs(sec_now)
    );

    resp_poll_div #(.CYCLES(POLL_CYCLES)) u_div (
        .clk(clk), .rst_n(rst_n), .enable(ctl_q.autopoll),
        .restart(div_restart), .due(poll_due)
    );

    resp_tx_buf #(.DEPTH(RBUF), .LW(LW)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_len(tx_len),
        .load_bytes(rb), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_len(out_len),
        .done(tx_done)
    );

    // returned data count clamped to what the reply buffer can carry
    assign n_ret = (int'(aux_cnt) > DMAX) ? AW'(DMAX) : aux_cnt;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.go        = 1'b0;
        ctl_d.off_pulse = 1'b0;
        ctl_d.rst_pulse = 1'b0;
        tx_load         = 1'b0;
        tx_len          = '0;
        rb              = '0;
        sec_load        = 1'b0;
        sec_val         = '0;
        div_restart     = 1'b0;

        if (!ctl_q.autopoll)    ctl_d.poll_pend = 1'b0;
        else if (poll_due)      ctl_d.poll_pend = 1'b1;

        if (tx_done) begin
            ctl_d.st = ST_IDLE;
            if (ctl_q.pend_off) begin
                ctl_d.off_pulse = 1'b1;
                ctl_d.pend_off  = 1'b0;
            end
            if (ctl_q.pend_rst) begin
                ctl_d.rst_pulse = 1'b1;
                ctl_d.pend_rst  = 1'b0;
            end
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (pkt_done) begin
                    if (pkt[0] == CLS_AUX) begin
                        ctl_d.st       = ST_AUX;
                        ctl_d.go       = 1'b1;
                        ctl_d.poll_fly = 1'b0;
                        ctl_d.req_len  = pkt_len - 1'b1;
                        for (int i = 1; i < IN_MAX; i++)
                            ctl_d.req_data[8*(i-1) +: 8] = pkt[i];
                    end else if (pkt[0] == CLS_CTL) begin
                        rb[0] = CLS_CTL;
                        case (pkt[1])
                            OP_POLL_SWITCH: begin
                                if ((pkt[2] != 8'h00) != ctl_q.autopoll) div_restart = 1'b1;
                                ctl_d.autopoll = (pkt[2] != 8'h00);
                                rb[1]   = pkt[2];
                                tx_len  = LW'(2);
                                tx_load = 1'b1;
                            end
                            OP_LOAD_CLOCK: begin
                                sec_load = 1'b1;
                                sec_val  = {pkt[2], pkt[3], pkt[4], pkt[5]};
                                tx_len   = LW'(3);
                                tx_load  = 1'b1;
                            end
                            OP_READ_CLOCK: begin
                                rb[3]   = sec_now[31:24];
                                rb[4]   = sec_now[23:16];
                                rb[5]   = sec_now[15:8];
                                rb[6]   = sec_now[7:0];
                                tx_len  = LW'(7);
                                tx_load = 1'b1;
                            end
                            OP_ACK_A, OP_ACK_B, OP_ACK_C, OP_ACK_D: begin
                                tx_len  = LW'(2);
                                tx_load = 1'b1;
                            end
                            OP_POWER_OFF: begin
                                ctl_d.pend_off = 1'b1;
                                tx_len  = LW'(2);
                                tx_load = 1'b1;
                            end
                            OP_RESTART: begin
                                ctl_d.pend_rst = 1'b1;
                                tx_len  = LW'(2);
                                tx_load = 1'b1;
                            end
                            default: ;
                        endcase
                        if (tx_load) ctl_d.st = ST_SEND;
                    end
                end else if (ctl_q.poll_pend && ctl_q.autopoll && !rx_active) begin
                    ctl_d.poll_pend = 1'b0;
                    ctl_d.poll_fly  = 1'b1;
                    ctl_d.go        = 1'b1;
                    ctl_d.st        = ST_AUX;
                end
            end
            ST_AUX: begin
                if (aux_done) begin
                    ctl_d.st = ST_IDLE;
                    rb[0]    = CLS_AUX;
                    if (aux_status == 8'h00) begin
                        for (int i = 0; i < DMAX; i++)
                            if (i < int'(n_ret)) rb[i+2] = aux_data[8*i +: 8];
                        if (ctl_q.poll_fly) begin
                            rb[1] = POLL_MARK;
                            if (n_ret != '0) tx_load = 1'b1;
                        end else begin
                            tx_load = 1'b1;
                        end
                        tx_len = LW'(n_ret) + LW'(2);
                    end else if (!ctl_q.poll_fly) begin
                        rb[1]   = aux_status;
                        tx_len  = LW'(2);
                        tx_load = 1'b1;
                    end
                    if (tx_load) ctl_d.st = ST_SEND;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign aux_go       = ctl_q.go;
    assign aux_poll     = ctl_q.poll_fly;
    assign aux_req_len  = ctl_q.req_len;
    assign aux_req_data = ctl_q.req_data;
    assign shutdown_req = ctl_q.off_pulse;
    assign reset_req    = ctl_q.rst_pulse;
endmodule

// File: rtl/resp_chk.sv
module resp_chk #(
    parameter int RBUF = 16,
    parameter int LW   = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_last,
    input logic [7:0]    out_data,
    input logic [LW-1:0] out_len,
    input logic          aux_go,
    input logic          shutdown_req,
    input logic          reset_req,
    input logic          sec_tick,
    input logic          sec_load,
    input logic [31:0]   sec_val,
    input logic [31:0]   sec_now
);
    // R11
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_len)));

    // R11
    reply_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LW'(2) && int'(out_len) <= RBUF));

    // R8
    req_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shutdown_req, reset_req}));

    // R8
    off_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_req || reset_req) |-> $past(out_valid && out_ready && out_last));

    // R6
    tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !sec_load) |=> (sec_now == $past(sec_now) + 32'd1));

    // R4
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_load |=> (sec_now == $past(sec_val)));

    // R9
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_go |=> !aux_go);

    // R12
    go_not_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_go |-> !out_valid);
endmodule

bind cmd_responder resp_chk #(.RBUF(RBUF), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_data(out_data), .out_len(out_len),
    .aux_go(aux_go), .shutdown_req(shutdown_req), .reset_req(reset_req),
    .sec_tick(sec_tick), .sec_load(sec_load), .sec_val(sec_val),
    .sec_now(sec_now)
);

// File: tb/sim_cmd_responder.sv
`timescale 1ns/1ps
module sim_cmd_responder;
    localparam int P  = 100;
    localparam int LW = 5;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, sec_tick = 1'b0, out_ready = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic out_valid, out_last, aux_go, aux_poll, shutdown_req, reset_req;
    logic [7:0] out_data;
    logic [LW-1:0] out_len, aux_req_len;
    logic [55:0] aux_req_data;
    logic aux_done = 1'b0;
    logic [7:0] aux_status = 8'h00;
    logic [AW-1:0] aux_cnt = '0;
    logic [63:0] aux_data = '0;

    always #5 clk = ~clk;

    cmd_responder #(.POLL_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .sec_tick(sec_tick), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_len(out_len),
        .out_ready(out_ready), .aux_go(aux_go), .aux_poll(aux_poll),
        .aux_req_len(aux_req_len), .aux_req_data(aux_req_data),
        .aux_done(aux_done), .aux_status(aux_status), .aux_cnt(aux_cnt),
        .aux_data(aux_data), .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    int errors = 0, checks = 0, cyc = 0;
    logic [7:0] pkt [16];
    logic [7:0] exp_b [16];
    logic [7:0] got [16];
    int got_n, exp_n;
    bit len_ok;

    // aux device model state
    int dly = 0, go_cnt = 0, poll_cnt = 0, poll_last = 0, poll_prev = 0;
    bit fly_poll = 0;
    int poll_ret = 0, req_ret = 0;
    logic [7:0] req_stat = 8'h00;
    logic [LW-1:0] seen_len;
    logic [55:0] seen_data;
    int off_cnt = 0, rst_cnt = 0, off_gap = 0, rst_gap = 0, last_acc = 0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (aux_done) aux_done = 1'b0;
        if (out_valid && out_ready && out_last) last_acc = cyc;
        if (shutdown_req) begin off_cnt++; off_gap = cyc - last_acc; end
        if (reset_req)    begin rst_cnt++; rst_gap = cyc - last_acc; end
        if (aux_go) begin
            go_cnt++;
            fly_poll = aux_poll;
            if (aux_poll) begin poll_cnt++; poll_prev = poll_last; poll_last = cyc; end
            seen_len  = aux_req_len;
            seen_data = aux_req_data;
            dly = 2;
        end else if (dly > 0) begin
            dly--;
            if (dly == 0) begin
                aux_done   = 1'b1;
                aux_status = fly_poll ? 8'h00 : req_stat;
                aux_cnt    = AW'(fly_poll ? poll_ret : req_ret);
                for (int i = 0; i < 8; i++)
                    aux_data[8*i +: 8] = (fly_poll ? 8'hA0 : 8'hC0) + 8'(i);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pkt[i]; in_last = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic collect(input int tmo);
        int w;
        got_n = 0; len_ok = 1; w = 0;
        while (!out_valid && w < tmo) begin @(negedge clk); w++; end
        while (out_valid && got_n < 16) begin
            if (out_ready) begin
                got[got_n] = out_data;
                if (int'(out_len) != exp_n) len_ok = 0;
                got_n++;
                if (out_last) begin @(negedge clk); break; end
            end
            @(negedge clk);
        end
    endtask

    task automatic check_reply(input string tag, input string what);
        bit ok;
        int bad;
        ok = (got_n == exp_n) && len_ok; bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (got[i] !== exp_b[i]) begin ok = 0; if (bad < 0) bad = i; end
        if (bad < 0) chk(ok, tag, {what, " length"}, got_n, exp_n);
        else chk(ok, tag, {what, " byte"}, int'(got[bad]), int'(exp_b[bad]));
    endtask

    task automatic set_exp(input int n, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        exp_n = n; exp_b[0] = b0; exp_b[1] = b1; exp_b[2] = b2;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [31:0] t;
        int pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!out_valid && !aux_go && !shutdown_req && !reset_req, "R1", "outputs idle", int'(out_valid), 0);
        repeat (3 * P) @(negedge clk);
        chk(go_cnt == 0, "R1", "no poll after reset", go_cnt, 0);
        pkt[0] = 8'h01; pkt[1] = 8'h03; send(2);
        exp_n = 7; exp_b[0] = 8'h01;
        for (int i = 1; i < 7; i++) exp_b[i] = 8'h00;
        collect(50); check_reply("R1", "seconds read zero after reset");

        // R2/R3/R4/R5/R7/R8 sweep of all command codes 0x00..0x2F with no arguments
        t = 32'h0;
        for (int c = 0; c < 48; c++) begin
            pkt[0] = 8'h01; pkt[1] = 8'(c); send(2);
            case (c)
                8'h01: set_exp(2, 8'h01, 8'h00, 8'h00);
                8'h03: begin exp_n = 7; exp_b[0] = 8'h01; exp_b[1] = 0; exp_b[2] = 0;
                           exp_b[3] = t[31:24]; exp_b[4] = t[23:16]; exp_b[5] = t[15:8]; exp_b[6] = t[7:0]; end
                8'h09: begin set_exp(3, 8'h01, 8'h00, 8'h00); t = 32'h0; end
                8'h0A, 8'h11, 8'h13, 8'h14, 8'h19, 8'h21: set_exp(2, 8'h01, 8'h00, 8'h00);
                default: exp_n = 0;
            endcase
            collect(30);
            if (c == 1)       check_reply("R3", $sformatf("sweep cmd %0h", c));
            else if (c == 3)  check_reply("R5", $sformatf("sweep cmd %0h", c));
            else if (c == 9)  check_reply("R4", $sformatf("sweep cmd %0h", c));
            else if (c == 10 || c == 17) check_reply("R8", $sformatf("sweep cmd %0h", c));
            else if (exp_n == 2) check_reply("R7", $sformatf("sweep cmd %0h", c));
            else check_reply("R2", $sformatf("sweep cmd %0h", c));
            repeat (3) @(negedge clk);
        end
        chk(off_cnt == 1 && off_gap == 1, "R8", "shutdown pulse after last byte", off_cnt * 16 + off_gap, 17);
        chk(rst_cnt == 1 && rst_gap == 1, "R8", "reset pulse after last byte", rst_cnt * 16 + rst_gap, 17);

        // R2 unknown packet classes
        for (int k = 2; k < 6; k++) begin
            pkt[0] = 8'(k); pkt[1] = 8'h03; send(2);
            exp_n = 0; collect(30); check_reply("R2", $sformatf("class %0d ignored", k));
        end

        // R4/R5/R6 big-endian load, ticks, wrap
        pkt[0] = 8'h01; pkt[1] = 8'h09; pkt[2] = 8'h12; pkt[3] = 8'h34; pkt[4] = 8'h56; pkt[5] = 8'h78;
        send(6); set_exp(3, 8'h01, 8'h00, 8'h00); collect(30); check_reply("R4", "load clock ack");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        end
        pkt[1] = 8'h03; send(2);
        t = 32'h1234567B; exp_n = 7; exp_b[0] = 8'h01; exp_b[1] = 0; exp_b[2] = 0;
        exp_b[3] = t[31:24]; exp_b[4] = t[23:16]; exp_b[5] = t[15:8]; exp_b[6] = t[7:0];
        collect(30); check_reply("R6", "three ticks after load");
        pkt[1] = 8'h09; pkt[2] = 8'hFF; pkt[3] = 8'hFF; pkt[4] = 8'hFF; pkt[5] = 8'hFE;
        send(6); set_exp(3, 8'h01, 8'h00, 8'h00); collect(30);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        end
        pkt[1] = 8'h03; send(2);
        exp_n = 7; for (int i = 1; i < 6; i++) exp_b[i] = 8'h00; exp_b[6] = 8'h01;
        collect(30); check_reply("R6", "wrap past all ones");

        // R9 auxiliary request: sweep returned counts, error, clamp
        for (int n = 0; n <= 8; n++) begin
            req_stat = 8'h00; req_ret = n;
            pkt[0] = 8'h00; pkt[1] = 8'h2C; pkt[2] = 8'h11; send(3);
            exp_n = n + 2; exp_b[0] = 8'h00; exp_b[1] = 8'h00;
            for (int i = 0; i < n; i++) exp_b[i+2] = 8'hC0 + 8'(i);
            collect(40); check_reply("R9", $sformatf("aux success n=%0d", n));
        end
        chk(seen_len == 5'd2 && seen_data[15:0] == 16'h112C, "R9", "request fields", int'(seen_data[15:0]), 16'h112C);
        req_ret = 15; send(3);
        exp_n = 10; for (int i = 0; i < 8; i++) exp_b[i+2] = 8'hC0 + 8'(i);
        collect(40); check_reply("R9", "count clamped");
        req_stat = 8'h05; req_ret = 3; send(3);
        set_exp(2, 8'h00, 8'h05, 8'h00); collect(40); check_reply("R9", "aux error");
        req_stat = 8'h00;

        // R12 packet during drain dropped
        out_ready = 1'b0;
        pkt[0] = 8'h01; pkt[1] = 8'h13; send(2);
        repeat (3) @(negedge clk);
        pkt[1] = 8'h03; send(2);
        out_ready = 1'b1;
        set_exp(2, 8'h01, 8'h00, 8'h00); collect(30); check_reply("R11", "stalled reply intact");
        exp_n = 0; collect(40); check_reply("R12", "command during drain dropped");

        // R10 autopoll
        poll_ret = 2;
        pkt[0] = 8'h01; pkt[1] = 8'h01; pkt[2] = 8'h07; send(3);
        set_exp(2, 8'h01, 8'h07, 8'h00); collect(30); check_reply("R3", "poll switch on echoes arg");
        exp_n = 4; exp_b[0] = 8'h00; exp_b[1] = 8'h40; exp_b[2] = 8'hA0; exp_b[3] = 8'hA1;
        collect(2 * P); check_reply("R10", "poll data forwarded");
        poll_ret = 0;
        pc = poll_cnt;
        while (poll_cnt < pc + 3) @(negedge clk);
        chk(poll_last - poll_prev == P, "R10", "poll interval", poll_last - poll_prev, P);
        exp_n = 0; collect(5); check_reply("R10", "empty poll no reply");
        repeat (8) @(negedge clk);
        pkt[2] = 8'h00; send(3);
        set_exp(2, 8'h01, 8'h00, 8'h00); collect(30); check_reply("R3", "poll switch off");
        pc = poll_cnt;
        repeat (3 * P) @(negedge clk);
        chk(poll_cnt == pc, "R3", "no polls when off", poll_cnt, pc);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule